// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block joins two eight-input priority resolvers into one sixteen-input interrupt controller. The upper unit, called the master, drives the CPU interrupt line. The lower unit, called the slave, gathers inputs 8 to 15. Whenever the slave holds a winning request, it raises a request on master pin 2. So a slave interrupt reaches the CPU through the master's priority and in-service logic.

The CPU answers with a single-cycle acknowledge strobe. In that same cycle the block returns an 8-bit vector and marks the serviced inputs as in service. A master winner on any pin other than 2 gives the master base plus the pin number. A master winner on pin 2 hands the acknowledge on to the slave. If a unit has nothing left to serve at acknowledge time, the vector is that unit's base plus 7, and the unit is not changed.

A small byte-wide register bus sets up both units. Per unit it writes the mask, the vector base, the trigger-mode register and a non-specific end-of-interrupt command. Bit 0 of the address always selects the unit.

Top module: `irq_cascade_pair`

## Requirements
- R1: Input n (0 to 15) is a request on unit n>>3 (0 = master, 1 = slave), pin n&7. Input 2 also feeds master pin 2 directly, and a lone input 2 acknowledges as a spurious slave interrupt (slave base + 7).
- R2: With its trigger-mode bit clear, a pin latches a request on a rising edge of its input. The request stays pending after the input falls, and the acknowledge clears it.
- R3: With its trigger-mode bit set, a pin's request follows the input level. The acknowledge does not clear it, so after end-of-interrupt it asks again while the input is high. It drops one cycle after the input falls.
- R4: A trigger-mode write keeps only the allowed bits: master mask 0xF8, slave mask 0xDE. Address 6 selects the master and address 7 the slave. Read-back returns the stored value.
- R5: int_o is high exactly when the master has an unmasked pending request that beats every master pin in service. int_o is re-evaluated in the cycle after an acknowledge or a register write.
- R6: Whenever the slave has a winner, master pin 2 receives a request. On acknowledge of master pin 2 with a slave winner, the vector is slave base + slave pin. Both master in-service bit 2 and the slave's in-service bit are set.
- R7: On acknowledge of a master winner on a pin other than 2, the vector is master base + pin, and that master in-service bit is set.
- R8: On acknowledge of master pin 2 when the slave has no winner, the vector is slave base + 7. Master in-service bit 2 is set and the slave is left unchanged.
- R9: Acknowledge while the master has no winner returns master base + 7 and sets no in-service bit.
- R10: Pin 0 has the highest priority and pin 7 the lowest. A pending pin wins only if it outranks every in-service pin of its unit. End-of-interrupt clears the highest-priority in-service bit of the unit.
- R11: A set mask bit keeps that pin from winning. Clearing the mask bit lets it win again.
- R12: A vector base write keeps only bits 7:3. Read-back of the base shows the low three bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 16 | Interrupt request inputs |
| int_o | output | 1 | Interrupt line to the CPU |
| ack_i | input | 1 | Single-cycle interrupt acknowledge strobe |
| vec_o | output | 8 | Vector for the acknowledge in the current cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address. Bits 2:1: 0 mask, 1 base, 2 end-of-interrupt (write) or in-service (read), 3 trigger mode. Bit 0 selects the unit |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the addressed register |

## Verification
The checker assumes each acknowledge lasts one cycle. It also assumes that an end-of-interrupt is never written in the same cycle as an acknowledge to the same unit. The bench keeps to both by pulsing ack_i for exactly one clock and by writing the end-of-interrupt only after ack_i has fallen. Request inputs change only in the low clock phase and are held for at least one cycle, so every rising edge meant as a request is sampled.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int UNIT_W  = 8;
  localparam int ID_W    = $clog2(UNIT_W);
  localparam int VEC_W   = 8;
  localparam int N_UNITS = 2;
  localparam int CAS_PIN = 2;
  localparam logic [UNIT_W-1:0] TRIG_MASK_M = 8'hF8;
  localparam logic [UNIT_W-1:0] TRIG_MASK_S = 8'hDE;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_EOI  = 2'd2,
    REG_TRIG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int          W         = 8,
  parameter int          VW        = 8,
  parameter logic [W-1:0] TRIG_MASK = '1,
  localparam int         IW        = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req,
  input  logic [W-1:0]  force_set,
  input  logic          wr_mask,
  input  logic          wr_base,
  input  logic          wr_trig,
  input  logic          wr_eoi,
  input  logic [VW-1:0] wdata,
  input  logic          ack,
  input  logic [IW-1:0] ack_id,
  output logic          win_valid,
  output logic [IW-1:0] win_id,
  output logic [W-1:0]  mask_o,
  output logic [VW-1:0] base_o,
  output logic [W-1:0]  isr_o,
  output logic [W-1:0]  trig_o
);
  logic [W-1:0]     irr_q, isr_q, mask_q, trig_q, req_q;
  logic [VW-1:IW]   base_q;
  logic [W-1:0]     irr_d, isr_d, pend, eoi_clr, ack_set;
  logic [IW-1:0]    pend_idx, isr_idx;
  logic             pend_any, isr_any;

  always_comb begin
    pend     = irr_q & ~mask_q;
    pend_idx = '0;
    pend_any = 1'b0;
    isr_idx  = '0;
    isr_any  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pend_idx = IW'(i);
        pend_any = 1'b1;
      end
      if (isr_q[i]) begin
        isr_idx = IW'(i);
        isr_any = 1'b1;
      end
    end
    win_valid = pend_any && (!isr_any || (pend_idx < isr_idx));
    win_id    = pend_idx;
  end

  always_comb begin
    eoi_clr = '0;
    ack_set = '0;
    if (wr_eoi && isr_any) eoi_clr[isr_idx] = 1'b1;
    if (ack)               ack_set[ack_id]  = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (trig_q[i]) irr_d[i] = req[i];
      else           irr_d[i] = irr_q[i] | (req[i] & ~req_q[i]);
    end
    irr_d = irr_d | force_set;
    irr_d = irr_d & ~(ack_set & ~trig_q);
    isr_d = (isr_q & ~eoi_clr) | ack_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      req_q  <= '0;
      mask_q <= '0;
      trig_q <= '0;
      base_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      req_q <= req;
      if (wr_mask) mask_q <= wdata[W-1:0];
      if (wr_trig) trig_q <= wdata[W-1:0] & TRIG_MASK;
      if (wr_base) base_q <= wdata[VW-1:IW];
    end
  end

  assign mask_o = mask_q;
  assign trig_o = trig_q;
  assign isr_o  = isr_q;
  assign base_o = {base_q, {IW{1'b0}}};
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
  import irq_cascade_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_UNITS*UNIT_W-1:0]    irq_in,
  output logic                         int_o,
  input  logic                         ack_i,
  output logic [VEC_W-1:0]             vec_o,
  input  logic                         bus_wr,
  input  logic [2:0]                   bus_addr,
  input  logic [VEC_W-1:0]             bus_wdata,
  output logic [VEC_W-1:0]             bus_rdata
);
  localparam logic [ID_W-1:0] CAS_ID   = ID_W'(CAS_PIN);
  localparam logic [ID_W-1:0] SPUR_ID  = ID_W'(UNIT_W - 1);

  logic                               srst_n;
  logic [N_UNITS-1:0]                 win_valid_v, ack_v;
  logic [N_UNITS-1:0]                 wr_mask_v, wr_base_v, wr_trig_v, wr_eoi_v;
  logic [N_UNITS-1:0][ID_W-1:0]       win_id_v, ack_id_v;
  logic [N_UNITS-1:0][UNIT_W-1:0]     force_v, mask_v, isr_v, trig_v;
  logic [N_UNITS-1:0][VEC_W-1:0]      base_v;
  reg_sel_e                           sel;
  logic                               unit_sel;
  logic                               m_cas;

  irq_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign sel      = reg_sel_e'(bus_addr[2:1]);
  assign unit_sel = bus_addr[0];

  always_comb begin
    for (int u = 0; u < N_UNITS; u++) begin
      wr_mask_v[u] = bus_wr && (unit_sel == u[0]) && (sel == REG_MASK);
      wr_base_v[u] = bus_wr && (unit_sel == u[0]) && (sel == REG_BASE);
      wr_eoi_v[u]  = bus_wr && (unit_sel == u[0]) && (sel == REG_EOI);
      wr_trig_v[u] = bus_wr && (unit_sel == u[0]) && (sel == REG_TRIG);
    end
  end

  always_comb begin
    force_v    = '0;
    force_v[0] = UNIT_W'(win_valid_v[1]) << CAS_PIN;
    m_cas      = win_valid_v[0] && (win_id_v[0] == CAS_ID);
    ack_v[0]   = ack_i && win_valid_v[0];
    ack_id_v[0] = win_id_v[0];
    ack_v[1]   = ack_i && m_cas && win_valid_v[1];
    ack_id_v[1] = win_id_v[1];
    if (!win_valid_v[0])    vec_o = base_v[0] | VEC_W'(SPUR_ID);
    else if (!m_cas)        vec_o = base_v[0] | VEC_W'(win_id_v[0]);
    else if (win_valid_v[1]) vec_o = base_v[1] | VEC_W'(win_id_v[1]);
    else                    vec_o = base_v[1] | VEC_W'(SPUR_ID);
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    irq_unit #(
      .W        (UNIT_W),
      .VW       (VEC_W),
      .TRIG_MASK((u == 0) ? TRIG_MASK_M : TRIG_MASK_S)
    ) u_unit (
      .clk      (clk),
      .rst_n    (srst_n),
      .req      (irq_in[u*UNIT_W +: UNIT_W]),
      .force_set(force_v[u]),
      .wr_mask  (wr_mask_v[u]),
      .wr_base  (wr_base_v[u]),
      .wr_trig  (wr_trig_v[u]),
      .wr_eoi   (wr_eoi_v[u]),
      .wdata    (bus_wdata),
      .ack      (ack_v[u]),
      .ack_id   (ack_id_v[u]),
      .win_valid(win_valid_v[u]),
      .win_id   (win_id_v[u]),
      .mask_o   (mask_v[u]),
      .base_o   (base_v[u]),
      .isr_o    (isr_v[u]),
      .trig_o   (trig_v[u])
    );
  end

  assign int_o = win_valid_v[0];

  always_comb begin
    case (sel)
      REG_MASK: bus_rdata = mask_v[unit_sel];
      REG_BASE: bus_rdata = base_v[unit_sel];
      REG_EOI:  bus_rdata = isr_v[unit_sel];
      default:  bus_rdata = trig_v[unit_sel];
    endcase
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_cascade_pkg::*;
(
  input logic                         clk,
  input logic                         srst_n,
  input logic                         int_o,
  input logic                         ack_i,
  input logic [VEC_W-1:0]             vec_o,
  input logic [N_UNITS-1:0][ID_W-1:0] win_id_v,
  input logic [N_UNITS-1:0][UNIT_W-1:0] isr_v,
  input logic [N_UNITS-1:0][UNIT_W-1:0] trig_v,
  input logic [N_UNITS-1:0][VEC_W-1:0]  base_v
);
  AST_SPUR_MASTER: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_i && !int_o) |-> (vec_o == (base_v[0] | VEC_W'(UNIT_W - 1))));   // R9

  AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_i && int_o) |=> (isr_v[0] != '0));                             // R7

  AST_TRIG_ALLOWED: assert property (@(posedge clk) disable iff (!srst_n)
    ((trig_v[0] & ~TRIG_MASK_M) == '0) && ((trig_v[1] & ~TRIG_MASK_S) == '0)); // R4

  AST_CASCADE_BASE: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_i && int_o && (win_id_v[0] == ID_W'(CAS_PIN)))
      |-> (vec_o[VEC_W-1:ID_W] == base_v[1][VEC_W-1:ID_W]));            // R6

  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (base_v[0][ID_W-1:0] == '0) && (base_v[1][ID_W-1:0] == '0));         // R12
endmodule

bind irq_cascade_pair irq_cascade_chk u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .int_o   (int_o),
  .ack_i   (ack_i),
  .vec_o   (vec_o),
  .win_id_v(win_id_v),
  .isr_v   (isr_v),
  .trig_v  (trig_v),
  .base_v  (base_v)
);

// File: tb/sim_irq_cascade_pair.sv
`timescale 1ns/1ps
module sim_irq_cascade_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        int_o, ack_i, bus_wr;
  logic [7:0]  vec_o, bus_wdata, bus_rdata;
  logic [2:0]  bus_addr;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  // entry: {input index, expected vector}; bases 0x20 master, 0x70 slave
  localparam logic [11:0] TBL [8] = '{
    {4'd0, 8'h20}, {4'd1, 8'h21}, {4'd2, 8'h77}, {4'd5, 8'h25},
    {4'd7, 8'h27}, {4'd8, 8'h70}, {4'd11, 8'h73}, {4'd15, 8'h77}
  };

  always #2.5 clk = ~clk;

  irq_cascade_pair u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_o(int_o),
    .ack_i(ack_i), .vec_o(vec_o), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic do_ack(input logic [7:0] exp, input string tag);
    @(negedge clk);
    ack_i = 1'b1;
    #1;
    check(tag, vec_o, exp);
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; ack_i = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R5 reset int_o", {7'd0, int_o}, 8'h00);
    rd(3'd4, 8'h00, "R9 reset master isr");
    rd(3'd0, 8'h00, "R11 reset master mask");

    wr(3'd2, 8'h23);
    wr(3'd3, 8'h70);
    rd(3'd2, 8'h20, "R12 master base low bits");
    rd(3'd3, 8'h70, "R12 slave base");

    // R4 trigger-mode masks
    wr(3'd6, 8'hFF); rd(3'd6, 8'hF8, "R4 master trig mask");
    wr(3'd7, 8'hFF); rd(3'd7, 8'hDE, "R4 slave trig mask");
    rd(3'd6, 8'hF8, "R4 master unchanged by slave write");
    wr(3'd6, 8'h00); wr(3'd7, 8'h00);

    // R9 spurious master
    do_ack(8'h27, "R9 spurious master vector");
    rd(3'd4, 8'h00, "R9 master isr untouched");
    rd(3'd5, 8'h00, "R9 slave isr untouched");

    // R1 R6 R7 table walk
    for (int k = 0; k < 8; k++) begin
      int n;
      logic [7:0] mexp;
      n = int'(TBL[k][11:8]);
      mexp = (n >= 8 || n == 2) ? 8'h04 : 8'h01 << n;
      irq_in[n] = 1'b1;
      tick(3);
      check($sformatf("R5 int_o for input %0d", n), {7'd0, int_o}, 8'h01);
      do_ack(TBL[k][7:0], $sformatf("R1 R6 R7 vector for input %0d", n));
      rd(3'd4, mexp, $sformatf("R7 master isr for input %0d", n));
      if (n >= 8) rd(3'd5, 8'h01 << (n - 8), $sformatf("R6 slave isr for input %0d", n));
      irq_in[n] = 1'b0;
      if (n >= 8) wr(3'd5, 8'h00);
      wr(3'd4, 8'h00);
      tick(2);
      check($sformatf("R5 int_o clear after input %0d", n), {7'd0, int_o}, 8'h00);
    end

    // R11 mask
    wr(3'd0, 8'h20);
    irq_in[5] = 1'b1; tick(3);
    check("R11 masked pin no int", {7'd0, int_o}, 8'h00);
    wr(3'd0, 8'h00); tick(1);
    check("R11 unmasked pin int", {7'd0, int_o}, 8'h01);
    do_ack(8'h25, "R11 vector after unmask");
    irq_in[5] = 1'b0; wr(3'd4, 8'h00); tick(2);

    // R10 priority and nesting
    irq_in[3] = 1'b1; irq_in[6] = 1'b1; tick(3);
    do_ack(8'h23, "R10 lower index wins");
    irq_in[3] = 1'b0; irq_in[6] = 1'b0; tick(2);
    check("R10 pin6 blocked by isr3", {7'd0, int_o}, 8'h00);
    irq_in[1] = 1'b1; tick(3);
    check("R10 pin1 preempts", {7'd0, int_o}, 8'h01);
    do_ack(8'h21, "R10 nested vector");
    irq_in[1] = 1'b0;
    rd(3'd4, 8'h0A, "R10 nested isr");
    wr(3'd4, 8'h00); rd(3'd4, 8'h08, "R10 eoi clears highest");
    wr(3'd4, 8'h00); tick(2);
    check("R10 pin6 released", {7'd0, int_o}, 8'h01);
    do_ack(8'h26, "R10 pin6 vector");
    wr(3'd4, 8'h00); tick(2);

    // R2 edge request stays after input falls
    irq_in[4] = 1'b1; tick(1); irq_in[4] = 1'b0; tick(2);
    check("R2 edge latched", {7'd0, int_o}, 8'h01);
    do_ack(8'h24, "R2 edge vector");
    wr(3'd4, 8'h00); tick(2);
    check("R2 ack cleared edge", {7'd0, int_o}, 8'h00);

    // R3 level request
    wr(3'd6, 8'h08);
    irq_in[3] = 1'b1; tick(3);
    do_ack(8'h23, "R3 level vector");
    wr(3'd4, 8'h00); tick(1);
    check("R3 level still pending", {7'd0, int_o}, 8'h01);
    irq_in[3] = 1'b0; tick(2);
    check("R3 level drops", {7'd0, int_o}, 8'h00);
    wr(3'd6, 8'h00);

    // R8 spurious slave
    irq_in[9] = 1'b1; tick(3);
    check("R6 slave request raises int", {7'd0, int_o}, 8'h01);
    wr(3'd1, 8'h02); tick(2);
    check("R8 master pin2 still pending", {7'd0, int_o}, 8'h01);
    do_ack(8'h77, "R8 spurious slave vector");
    rd(3'd5, 8'h00, "R8 slave isr untouched");
    rd(3'd4, 8'h04, "R8 master isr bit2");
    irq_in[9] = 1'b0;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00); tick(3);
    check("R6 unmasked slave cascades", {7'd0, int_o}, 8'h01);
    do_ack(8'h71, "R6 slave vector after unmask");
    wr(3'd5, 8'h00); wr(3'd4, 8'h00); tick(2);
    check("R5 idle at end", {7'd0, int_o}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule